// File: doc/BRIEF.md
# Bank Scrub Scheduler with Host I/O Interleaving

This block refreshes the contents of memory banks whose cells hold data for a limited time only. A scrub pass takes one bank, holds it away from the host, and walks every page of that bank in ascending order, issuing one page scrub command at a time. The page scrub itself (read, ECC check and correction, write-back) is done outside the block and reports completion with a done pulse and the number of bit errors it corrected. At every page boundary, if the host has an I/O queued for the bank being scrubbed, the bank is handed back to the host for exactly one access before scrubbing resumes. Passes visit the banks in round-robin order.

Passes start either on an external trigger or when an idle interval timer expires. The interval length is set by a small learning policy. At the end of each pass the total error count is quantised into low, medium or high. A 3x3 table of signed scores, indexed by that level and by an action (shorten, keep, lengthen), is updated from the outcome of the previous decision. The best-scoring action for the new level is then applied to the interval, which is clamped between programmable bounds. The policy is rewarded for low errors after lengthening and penalised for high errors after any action, so it trades scrub count against error rate.

Top module: `scrub_sched`

## Requirements
- R1: After reset no bank is held busy or granted, scrub_req is low, every score is zero and cur_intv equals cfg_max_intv.
- R2: A pass holds bank_busy one-hot on its bank, then requests pages 0 to PAGES-1 in ascending order. scrub_req, scrub_page and scrub_bank stay steady until the scrub_done that completes each page.
- R3: Successive passes use banks 0, 1, ..., NUM_BANKS-1 and then wrap to 0.
- R4: When a page that is not the last completes while io_req for the scrubbed bank is high, the bank is released: bank_busy goes low and bank_grant is one-hot on that bank. The grant is held until io_done, after which scrubbing resumes on the next page. A second queued I/O waits for the next page boundary.
- R5: When a page that is not the last completes and io_req for the scrubbed bank is low, the next page is requested in the following cycle. io_req bits of other banks have no effect.
- R6: When the last page completes, no grant is issued, whatever io_req holds. The bank stays busy for one more cycle while the policy updates, and is then freed.
- R7: scrub_trig while a pass is in progress is ignored and does not queue another pass.
- R8: Without a trigger, the next pass starts after all banks have been free for exactly cur_intv clock cycles.
- R9: The error level of a pass is the sum of err_cnt over its scrub_done cycles: LOW if sum <= cfg_err_lo, HIGH if sum > cfg_err_hi, otherwise MED.
- R10: At the end of a pass the action with the highest score for the new level is taken. Ties are broken in the order lengthen, keep, shorten for LOW; keep, lengthen, shorten for MED; shorten, keep, lengthen for HIGH. Shorten halves the interval, lengthen doubles it and keep leaves it unchanged, and the result is clamped.
- R11: At the end of every pass but the first since reset, the score of the previous decision is adjusted before the new action is chosen. It is decremented when the new level is HIGH, and incremented when the new level is LOW and the previous action was lengthen. Scores saturate at the signed limits.
- R12: cur_intv is always the stored interval clamped into [cfg_min_intv, cfg_max_intv], so changing a bound takes effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scrub_trig | input | 1 | Start a pass now (ignored during a pass) |
| io_req | input | NUM_BANKS | Host has an I/O queued, one bit per bank |
| io_done | input | 1 | Host finished the granted I/O |
| bank_busy | output | NUM_BANKS | One-hot: bank held by the scrubber |
| bank_grant | output | NUM_BANKS | One-hot: bank released for one host I/O |
| scrub_req | output | 1 | Page scrub command, held until scrub_done |
| scrub_bank | output | $clog2(NUM_BANKS) | Bank of the page scrub |
| scrub_page | output | $clog2(PAGES) | Page of the page scrub |
| scrub_done | input | 1 | Page scrub finished |
| err_cnt | input | ERR_W | Corrected bit errors of the finished page |
| cfg_min_intv | input | INTV_W | Lower interval bound |
| cfg_max_intv | input | INTV_W | Upper interval bound |
| cfg_err_lo | input | ERR_W+$clog2(PAGES)+1 | Pass sum at or below this is LOW |
| cfg_err_hi | input | ERR_W+$clog2(PAGES)+1 | Pass sum above this is HIGH |
| cur_intv | output | INTV_W | Effective idle interval in cycles |

## Verification
The bench keeps a host I/O queued across every page boundary of a pass. A design that let more than one I/O through per release, or granted the bank after the final page, would show a grant where the bench expects scrub_req or an idle bank. It measures the idle gap between passes cycle by cycle, which exposes an off-by-one interval counter, and fires a trigger in the middle of a pass to catch a scheduler that latches it as a second pass. The policy is driven through a fixed sequence of low, high and medium passes, including sums exactly at both thresholds. A wrong tie order, a reward applied to the wrong cell, a missed clamp or a choice made from the stale table each leads to a different interval than the one the bench predicts.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

    typedef enum logic [1:0] {
        ERR_LOW  = 2'd0,
        ERR_MED  = 2'd1,
        ERR_HIGH = 2'd2
    } err_lvl_e;

    typedef enum logic [1:0] {
        ACT_SHORTEN  = 2'd0,
        ACT_KEEP     = 2'd1,
        ACT_LENGTHEN = 2'd2
    } act_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ACQ   = 3'd1,
        S_SCRUB = 3'd2,
        S_REL   = 3'd3,
        S_END   = 3'd4
    } seq_state_e;

endpackage

// File: rtl/scrub_timer.sv
module scrub_timer #(
    parameter int INTV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic [INTV_W-1:0] intv,
    output logic              expire
);
    localparam int CNT_W = INTV_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    // Count idle cycles; expire on the last cycle of the interval.
    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (idle) begin
            cnt_d = cnt_q + CNT_W'(1);
            if (cnt_d >= {1'b0, intv}) begin
                expire = 1'b1;
            end
        end else begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/scrub_seq.sv
module scrub_seq
    import scrub_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int PAGES     = 16,
    parameter int ERR_W     = 6,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int PAGE_W   = $clog2(PAGES),
    localparam int SUM_W    = ERR_W + PAGE_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [NUM_BANKS-1:0] io_req,
    input  logic                 io_done,
    input  logic                 scrub_done,
    input  logic [ERR_W-1:0]     err_cnt,
    output logic [NUM_BANKS-1:0] bank_busy,
    output logic [NUM_BANKS-1:0] bank_grant,
    output logic                 scrub_req,
    output logic [BANK_W-1:0]    scrub_bank,
    output logic [PAGE_W-1:0]    scrub_page,
    output logic                 idle,
    output logic                 pass_end,
    output logic [SUM_W-1:0]     pass_sum
);
    localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(PAGES - 1);
    localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [BANK_W-1:0] bank;
        logic [PAGE_W-1:0] page;
        logic [SUM_W-1:0]  sum;
    } seq_t;

    seq_t s_d, s_q;
    logic [NUM_BANKS-1:0] bank_oh;

    assign bank_oh = NUM_BANKS'(1) << s_q.bank;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            S_IDLE: begin
                if (start) begin
                    s_d.st   = S_ACQ;
                    s_d.page = '0;
                    s_d.sum  = '0;
                end
            end
            S_ACQ: begin
                s_d.st = S_SCRUB;
            end
            S_SCRUB: begin
                if (scrub_done) begin
                    s_d.sum = s_q.sum + SUM_W'(err_cnt);
                    if (s_q.page == LAST_PAGE) begin
                        s_d.st = S_END;
                    end else begin
                        s_d.page = s_q.page + PAGE_W'(1);
                        s_d.st   = io_req[s_q.bank] ? S_REL : S_SCRUB;
                    end
                end
            end
            S_REL: begin
                if (io_done) begin
                    s_d.st = S_SCRUB;
                end
            end
            S_END: begin
                s_d.st   = S_IDLE;
                s_d.bank = (s_q.bank == LAST_BANK) ? '0 : s_q.bank + BANK_W'(1);
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: S_IDLE, bank: '0, page: '0, sum: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bank_busy  = (s_q.st == S_ACQ || s_q.st == S_SCRUB || s_q.st == S_END) ? bank_oh : '0;
        bank_grant = (s_q.st == S_REL) ? bank_oh : '0;
        scrub_req  = (s_q.st == S_SCRUB);
        scrub_bank = s_q.bank;
        scrub_page = s_q.page;
        idle       = (s_q.st == S_IDLE);
        pass_end   = (s_q.st == S_END);
        pass_sum   = s_q.sum;
    end
endmodule

// File: rtl/scrub_policy.sv
module scrub_policy
    import scrub_pkg::*;
#(
    parameter int INTV_W  = 16,
    parameter int SUM_W   = 11,
    parameter int SCORE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pass_end,
    input  logic [SUM_W-1:0]  pass_sum,
    input  logic [INTV_W-1:0] cfg_min_intv,
    input  logic [INTV_W-1:0] cfg_max_intv,
    input  logic [SUM_W-1:0]  cfg_err_lo,
    input  logic [SUM_W-1:0]  cfg_err_hi,
    output logic [INTV_W-1:0] cur_intv
);
    localparam logic signed [SCORE_W-1:0] SCORE_MAX = {1'b0, {(SCORE_W-1){1'b1}}};
    localparam logic signed [SCORE_W-1:0] SCORE_MIN = {1'b1, {(SCORE_W-1){1'b0}}};

    typedef logic [2:0][2:0][SCORE_W-1:0] tbl_t;

    typedef struct packed {
        tbl_t              tbl;
        logic              prev_vld;
        err_lvl_e          prev_lvl;
        act_e              prev_act;
        logic [INTV_W-1:0] intv;
    } pol_t;

    pol_t p_d, p_q;

    function automatic logic [INTV_W-1:0] clamp(input logic [INTV_W-1:0] v,
                                                input logic [INTV_W-1:0] lo,
                                                input logic [INTV_W-1:0] hi);
        logic [INTV_W-1:0] r;
        r = (v < lo) ? lo : v;
        r = (r > hi) ? hi : r;
        return r;
    endfunction

    err_lvl_e                 lvl;
    tbl_t                     tbl_upd;
    logic signed [SCORE_W-1:0] old_s;
    logic signed [SCORE_W-1:0] best_s;
    logic signed [SCORE_W-1:0] cand_s;
    act_e                     cand [3];
    act_e                     best;
    logic [INTV_W-1:0]        base;
    logic [INTV_W-1:0]        nxt;

    always_comb begin
        p_d = p_q;

        // Quantise the pass error sum.
        if (pass_sum <= cfg_err_lo) begin
            lvl = ERR_LOW;
        end else if (pass_sum > cfg_err_hi) begin
            lvl = ERR_HIGH;
        end else begin
            lvl = ERR_MED;
        end

        // Reward or penalise the previous decision.
        tbl_upd = p_q.tbl;
        old_s   = p_q.tbl[p_q.prev_lvl][p_q.prev_act];
        if (p_q.prev_vld) begin
            if (lvl == ERR_HIGH) begin
                if (old_s != SCORE_MIN) begin
                    tbl_upd[p_q.prev_lvl][p_q.prev_act] = old_s - SCORE_W'(1);
                end
            end else if (lvl == ERR_LOW && p_q.prev_act == ACT_LENGTHEN) begin
                if (old_s != SCORE_MAX) begin
                    tbl_upd[p_q.prev_lvl][p_q.prev_act] = old_s + SCORE_W'(1);
                end
            end
        end

        // Tie-break order depends on the observed level.
        unique case (lvl)
            ERR_LOW:  begin cand[0] = ACT_LENGTHEN; cand[1] = ACT_KEEP;     cand[2] = ACT_SHORTEN;  end
            ERR_HIGH: begin cand[0] = ACT_SHORTEN;  cand[1] = ACT_KEEP;     cand[2] = ACT_LENGTHEN; end
            default:  begin cand[0] = ACT_KEEP;     cand[1] = ACT_LENGTHEN; cand[2] = ACT_SHORTEN;  end
        endcase

        best   = cand[0];
        best_s = tbl_upd[lvl][cand[0]];
        for (int i = 1; i < 3; i++) begin
            cand_s = tbl_upd[lvl][cand[i]];
            if (cand_s > best_s) begin
                best   = cand[i];
                best_s = cand_s;
            end
        end

        // Apply the chosen action to the effective interval.
        base = clamp(p_q.intv, cfg_min_intv, cfg_max_intv);
        unique case (best)
            ACT_SHORTEN:  nxt = base >> 1;
            ACT_LENGTHEN: nxt = (base > (cfg_max_intv >> 1)) ? cfg_max_intv : (base << 1);
            default:      nxt = base;
        endcase

        if (pass_end) begin
            p_d.tbl      = tbl_upd;
            p_d.prev_vld = 1'b1;
            p_d.prev_lvl = lvl;
            p_d.prev_act = best;
            p_d.intv     = clamp(nxt, cfg_min_intv, cfg_max_intv);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '{tbl: '0, prev_vld: 1'b0, prev_lvl: ERR_LOW, prev_act: ACT_KEEP, intv: '1};
        end else begin
            p_q <= p_d;
        end
    end

    assign cur_intv = clamp(p_q.intv, cfg_min_intv, cfg_max_intv);
endmodule

// File: rtl/scrub_sched.sv
module scrub_sched
    import scrub_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int PAGES     = 16,
    parameter int ERR_W     = 6,
    parameter int INTV_W    = 16,
    parameter int SCORE_W   = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int PAGE_W   = $clog2(PAGES),
    localparam int SUM_W    = ERR_W + PAGE_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scrub_trig,
    input  logic [NUM_BANKS-1:0] io_req,
    input  logic                 io_done,
    output logic [NUM_BANKS-1:0] bank_busy,
    output logic [NUM_BANKS-1:0] bank_grant,
    output logic                 scrub_req,
    output logic [BANK_W-1:0]    scrub_bank,
    output logic [PAGE_W-1:0]    scrub_page,
    input  logic                 scrub_done,
    input  logic [ERR_W-1:0]     err_cnt,
    input  logic [INTV_W-1:0]    cfg_min_intv,
    input  logic [INTV_W-1:0]    cfg_max_intv,
    input  logic [SUM_W-1:0]     cfg_err_lo,
    input  logic [SUM_W-1:0]     cfg_err_hi,
    output logic [INTV_W-1:0]    cur_intv
);
    logic             idle;
    logic             expire;
    logic             start;
    logic             pass_end;
    logic [SUM_W-1:0] pass_sum;

    assign start = scrub_trig | expire;

    scrub_timer #(.INTV_W(INTV_W)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .idle   (idle),
        .intv   (cur_intv),
        .expire (expire)
    );

    scrub_seq #(.NUM_BANKS(NUM_BANKS), .PAGES(PAGES), .ERR_W(ERR_W)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .io_req     (io_req),
        .io_done    (io_done),
        .scrub_done (scrub_done),
        .err_cnt    (err_cnt),
        .bank_busy  (bank_busy),
        .bank_grant (bank_grant),
        .scrub_req  (scrub_req),
        .scrub_bank (scrub_bank),
        .scrub_page (scrub_page),
        .idle       (idle),
        .pass_end   (pass_end),
        .pass_sum   (pass_sum)
    );

    scrub_policy #(.INTV_W(INTV_W), .SUM_W(SUM_W), .SCORE_W(SCORE_W)) i_policy (
        .clk          (clk),
        .rst_n        (rst_n),
        .pass_end     (pass_end),
        .pass_sum     (pass_sum),
        .cfg_min_intv (cfg_min_intv),
        .cfg_max_intv (cfg_max_intv),
        .cfg_err_lo   (cfg_err_lo),
        .cfg_err_hi   (cfg_err_hi),
        .cur_intv     (cur_intv)
    );
endmodule

// File: rtl/scrub_sched_chk.sv
module scrub_sched_chk #(
    parameter int NUM_BANKS = 8,
    parameter int PAGES     = 16,
    parameter int INTV_W    = 16,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int PAGE_W   = $clog2(PAGES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_BANKS-1:0] io_req,
    input logic                 io_done,
    input logic [NUM_BANKS-1:0] bank_busy,
    input logic [NUM_BANKS-1:0] bank_grant,
    input logic                 scrub_req,
    input logic [BANK_W-1:0]    scrub_bank,
    input logic [PAGE_W-1:0]    scrub_page,
    input logic                 scrub_done,
    input logic [INTV_W-1:0]    cfg_min_intv,
    input logic [INTV_W-1:0]    cfg_max_intv,
    input logic [INTV_W-1:0]    cur_intv
);
    localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(PAGES - 1);

    assert_busy_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_busy));

    assert_req_holds_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_req |-> (bank_busy == (NUM_BANKS'(1) << scrub_bank)));

    assert_page_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (scrub_req && !scrub_done) |=> (scrub_req && $stable(scrub_page) && $stable(scrub_bank)));

    assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_grant) && !(|bank_grant && scrub_req));

    assert_grant_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_grant && !io_done) |=> $stable(bank_grant));

    assert_grant_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_grant && io_done) |=> (scrub_req && !(|bank_grant)));

    assert_next_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (scrub_req && scrub_done && !io_req[scrub_bank] && scrub_page != LAST_PAGE)
        |=> (scrub_req && scrub_page == $past(scrub_page) + PAGE_W'(1)));

    assert_last_no_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (scrub_req && scrub_done && scrub_page == LAST_PAGE) |=> (bank_grant == '0 && !scrub_req));

    assert_intv_bounds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_min_intv <= cfg_max_intv) |-> (cur_intv >= cfg_min_intv && cur_intv <= cfg_max_intv));
endmodule

bind scrub_sched scrub_sched_chk #(
    .NUM_BANKS (NUM_BANKS),
    .PAGES     (PAGES),
    .INTV_W    (INTV_W)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .io_req       (io_req),
    .io_done      (io_done),
    .bank_busy    (bank_busy),
    .bank_grant   (bank_grant),
    .scrub_req    (scrub_req),
    .scrub_bank   (scrub_bank),
    .scrub_page   (scrub_page),
    .scrub_done   (scrub_done),
    .cfg_min_intv (cfg_min_intv),
    .cfg_max_intv (cfg_max_intv),
    .cur_intv     (cur_intv)
);

// File: tb/test_scrub_sched.sv
`timescale 1ns/1ps
module test_scrub_sched;
    localparam int NB     = 8;
    localparam int PG     = 4;
    localparam int ERR_W  = 6;
    localparam int INTV_W = 12;
    localparam int BANK_W = $clog2(NB);
    localparam int PAGE_W = $clog2(PG);
    localparam int SUM_W  = ERR_W + PAGE_W + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              scrub_trig = 1'b0;
    logic [NB-1:0]     io_req = '0;
    logic              io_done = 1'b0;
    logic [NB-1:0]     bank_busy, bank_grant;
    logic              scrub_req;
    logic [BANK_W-1:0] scrub_bank;
    logic [PAGE_W-1:0] scrub_page;
    logic              scrub_done = 1'b0;
    logic [ERR_W-1:0]  err_cnt = '0;
    logic [INTV_W-1:0] cfg_min_intv = 12'd8;
    logic [INTV_W-1:0] cfg_max_intv = 12'd64;
    logic [SUM_W-1:0]  cfg_err_lo = 9'd2;
    logic [SUM_W-1:0]  cfg_err_hi = 9'd10;
    logic [INTV_W-1:0] cur_intv;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    scrub_sched #(.NUM_BANKS(NB), .PAGES(PG), .ERR_W(ERR_W), .INTV_W(INTV_W), .SCORE_W(4)) i_scrub_sched (
        .clk(clk), .rst_n(rst_n), .scrub_trig(scrub_trig), .io_req(io_req), .io_done(io_done),
        .bank_busy(bank_busy), .bank_grant(bank_grant), .scrub_req(scrub_req),
        .scrub_bank(scrub_bank), .scrub_page(scrub_page), .scrub_done(scrub_done),
        .err_cnt(err_cnt), .cfg_min_intv(cfg_min_intv), .cfg_max_intv(cfg_max_intv),
        .cfg_err_lo(cfg_err_lo), .cfg_err_hi(cfg_err_hi), .cur_intv(cur_intv)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; scrub_trig = 1'b0; io_req = '0; io_done = 1'b0;
        scrub_done = 1'b0; err_cnt = '0;
        cfg_min_intv = 12'd8; cfg_max_intv = 12'd64;
        cfg_err_lo = 9'd2; cfg_err_hi = 9'd10;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic trig_pass();
        scrub_trig = 1'b1;
        @(negedge clk);
        scrub_trig = 1'b0;
    endtask

    task automatic serve_page(input int bank, input int page, input int err);
        int n = 0;
        while (!scrub_req && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk(scrub_req == 1'b1, "R2 scrub_req", int'(scrub_req), 1);
        chk(int'(scrub_bank) == bank, "R3 scrub_bank", int'(scrub_bank), bank);
        chk(int'(scrub_page) == page, "R2 scrub_page", int'(scrub_page), page);
        scrub_done = 1'b1;
        err_cnt = ERR_W'(err);
        @(negedge clk);
        scrub_done = 1'b0;
        err_cnt = '0;
    endtask

    task automatic run_pass(input int bank, input int e0, input int e1, input int e2, input int e3);
        trig_pass();
        serve_page(bank, 0, e0);
        serve_page(bank, 1, e1);
        serve_page(bank, 2, e2);
        serve_page(bank, 3, e3);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (bank_busy != '0 && n < 50) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk(bank_busy == '0, "R1 busy", int'(bank_busy), 0);
        chk(bank_grant == '0, "R1 grant", int'(bank_grant), 0);
        chk(scrub_req == 1'b0, "R1 scrub_req", int'(scrub_req), 0);
        chk(cur_intv == 12'd64, "R1 cur_intv", int'(cur_intv), 64);
    endtask

    task automatic t_walk();
        do_reset();
        // R5: other banks' requests must not release bank 0
        io_req = 8'hFE;
        trig_pass();
        chk(bank_busy == 8'h01, "R2 busy on bank 0", int'(bank_busy), 1);
        for (int p = 0; p < PG - 1; p++) begin
            serve_page(0, p, 0);
            chk(scrub_req && int'(scrub_page) == p + 1 && bank_grant == '0,
                "R5 immediate next page", int'(scrub_page), p + 1);
        end
        serve_page(0, PG - 1, 0);
        chk(bank_busy == 8'h01 && !scrub_req, "R6 busy during update", int'(bank_busy), 1);
        @(negedge clk);
        chk(bank_busy == '0 && bank_grant == '0, "R6 bank freed", int'(bank_busy), 0);
        io_req = '0;
        // R3: round-robin over all banks, then wrap
        for (int b = 1; b <= NB; b++) begin
            trig_pass();
            chk(bank_busy == (NB'(1) << (b % NB)), "R3 busy bank", int'(bank_busy), 1 << (b % NB));
            serve_page(b % NB, 0, 0);
            serve_page(b % NB, 1, 0);
            serve_page(b % NB, 2, 0);
            serve_page(b % NB, 3, 0);
            wait_idle();
        end
    endtask

    task automatic t_io();
        do_reset();
        io_req = 8'h01;
        trig_pass();
        for (int p = 0; p < PG - 1; p++) begin
            serve_page(0, p, 0);
            chk(bank_grant == 8'h01 && bank_busy == '0 && !scrub_req,
                "R4 released for I/O", int'(bank_grant), 1);
            repeat (3) @(negedge clk);
            chk(bank_grant == 8'h01 && !scrub_req, "R4 grant held", int'(bank_grant), 1);
            io_done = 1'b1;
            @(negedge clk);
            io_done = 1'b0;
            // second queued I/O (io_req still high) must wait
            chk(scrub_req && bank_grant == '0 && int'(scrub_page) == p + 1,
                "R4 one I/O then resume", int'(scrub_page), p + 1);
        end
        serve_page(0, PG - 1, 0);
        chk(bank_grant == '0, "R6 no grant after last page", int'(bank_grant), 0);
        @(negedge clk);
        chk(bank_grant == '0 && bank_busy == '0, "R6 freed without grant", int'(bank_grant), 0);
        io_req = '0;
    endtask

    task automatic t_trig_ignored();
        do_reset();
        trig_pass();
        serve_page(0, 0, 0);
        scrub_trig = 1'b1;
        @(negedge clk);
        scrub_trig = 1'b0;
        serve_page(0, 1, 0);
        serve_page(0, 2, 0);
        serve_page(0, 3, 0);
        wait_idle();
        repeat (6) begin
            @(negedge clk);
            chk(bank_busy == '0 && !scrub_req, "R7 trigger during pass ignored", int'(bank_busy), 0);
        end
    endtask

    task automatic measure_gap(input int exp, input string req);
        int n = 0;
        wait_idle();
        while (bank_busy == '0 && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk(n == exp, req, n, exp);
    endtask

    task automatic t_interval();
        do_reset();
        run_pass(0, 0, 0, 0, 0);
        measure_gap(64, "R8 idle gap 64");
        cfg_max_intv = 12'd20;
        serve_page(1, 0, 0);
        serve_page(1, 1, 0);
        serve_page(1, 2, 0);
        serve_page(1, 3, 0);
        measure_gap(20, "R8 idle gap 20");
    endtask

    task automatic policy_pass(input int bank, input int e0, input int e1, input int e2,
                               input int e3, input int exp, input string req);
        run_pass(bank, e0, e1, e2, e3);
        wait_idle();
        chk(int'(cur_intv) == exp, req, int'(cur_intv), exp);
    endtask

    task automatic t_policy();
        do_reset();
        policy_pass(0, 0, 0, 0, 0, 64, "R10 LOW tie picks lengthen, clamp max");
        policy_pass(1, 0, 1, 0, 1, 64, "R9 sum at low bound is LOW");
        policy_pass(2, 5, 5, 5, 5, 32, "R10 HIGH tie picks shorten");
        policy_pass(3, 5, 5, 5, 5, 32, "R11 penalised shorten, keep wins");
        policy_pass(4, 5, 5, 5, 5, 64, "R11 updated table used, lengthen wins");
        cfg_min_intv = 12'd48;
        policy_pass(5, 5, 5, 5, 5, 48, "R10 shorten clamped to min");
        policy_pass(6, 3, 3, 2, 2, 48, "R9 sum at high bound is MED, keep");
        cfg_min_intv = 12'd8;
        cfg_max_intv = 12'd40;
        @(negedge clk);
        chk(cur_intv == 12'd40, "R12 clamp to lowered max", int'(cur_intv), 40);
        cfg_max_intv = 12'd64;
        @(negedge clk);
        chk(cur_intv == 12'd48, "R12 stored value restored", int'(cur_intv), 48);
    endtask

    initial begin
        t_reset();
        t_walk();
        t_io();
        t_trig_ignored();
        t_interval();
        t_policy();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule